// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block sits beside a processor core and watches 32 level-sensitive external interrupt lines. Each line has an enable bit and a 4-bit priority. The block registers the raw lines into pending bits. From those bits it selects the most urgent request that may preempt the work in progress, and it raises a single request output toward the core whenever such a request exists.

Software reaches the block through a small register port. The port has a 3-bit word address, write data, and three strobes: whole-word write, bit-set and bit-clear. Read data is combinational and reflects the state in the cycle of the access.

A dispatch loop reads the next-interrupt word. Its index field is already scaled to a byte offset into a table of 4-byte handler entries. Its sign bit says that nothing is left to service. If the loop sets bit 0 in the same access, the block records the chosen interrupt's number and preemption threshold in a context word. Saving and restoring that context word lets nested dispatch unwind. The context word can also clear the core's software and timer interrupt enables and keep a copy of their previous values.

Top module: `eirq_arbiter`

## Requirements
- R1: After reset, the enable, priority and context words read 0, irq_o is low, ts_clr_o is low and the next word (address 6) reads 32'h8000_0000.
- R2: The next word returns the number of the highest-priority eligible interrupt in bits [6:2], with all other bits 0. An interrupt is eligible when it is pending and enabled and its priority is at or above the threshold. Priority words at addresses 2 to 5 hold interrupt 8k+j of word k in bits [4j+3:4j].
- R3: When several eligible interrupts share the highest priority, the lowest-numbered one is returned.
- R4: When no interrupt is eligible, bit 31 of the next word is 1 and bits [30:0] are 0.
- R5: The threshold is the 5-bit field in context bits [20:16]. An interrupt whose priority equals the threshold is eligible, and one whose priority is below it is not.
- R6: A set strobe on address 6 with write data bit 0 at 1 returns the pre-update next word in that access. If that word was not empty, then from the following cycle the context threshold is the returned priority plus 1 and context bits [12:8] hold the returned number.
- R7: The same update access, made while the next word is empty, leaves the context word unchanged.
- R8: Pending bits (address 1) equal irq_i delayed by one clock, and the next word uses the pending bits as they stand in the cycle of the read. A higher-priority line that rises after a lower one but before the read is the one reported.
- R9: A write or set to the context word (address 7) with data bit 1 at 1 captures core_msie_i into context bit 3 and core_mtie_i into context bit 2, and pulses ts_clr_o high for exactly the following cycle. Context bit 1 always reads 0.
- R10: A whole-word write to the context word with data bit 1 at 0 loads bits [20:16], [12:8], 3 and 2 from the write data. This restores a saved threshold and number.
- R11: Set and clear strobes OR in or mask out the written bits of the enable and priority words. Writes to the pending word or to the next word have no effect on any register.
- R12: irq_o is high exactly when the next word's bit 31 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level-sensitive external interrupt lines |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data, also the bit mask for set and clear |
| wr_i | input | 1 | Whole-word write strobe |
| set_i | input | 1 | Bit-set strobe |
| clr_i | input | 1 | Bit-clear strobe |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Request toward the core: an eligible interrupt exists |
| core_msie_i | input | 1 | Current core software interrupt enable |
| core_mtie_i | input | 1 | Current core timer interrupt enable |
| ts_clr_o | output | 1 | One-cycle pulse telling the core to clear its software and timer enables |

## Verification
A corrupted enable or priority bit, or a wrong pending bit, shows in the next-word read, and in irq_o, in the same cycle as the access. The bench compares every such read against a selection it computes itself from its own model. A wrong context update stays hidden until the threshold gates a later selection, so the bench reads the context word back one cycle after each update. Because the threshold is 5 bits wide, off-by-one and tie-order faults show up as a wrong index or a wrong empty flag within one access.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NUM_IRQ        = 32;
  localparam int PRIO_W         = 4;
  localparam int DATA_W         = 32;
  localparam int ADDR_W         = 3;
  localparam int IDX_W          = $clog2(NUM_IRQ);
  localparam int PRE_W          = PRIO_W + 1;
  localparam int PRIO_PER_WORD  = DATA_W / PRIO_W;
  localparam int NUM_PRIO_WORDS = NUM_IRQ / PRIO_PER_WORD;
  localparam int PW_IDX_W       = $clog2(NUM_PRIO_WORDS);

  // word map
  localparam int ADDR_EN    = 0;
  localparam int ADDR_PEND  = 1;
  localparam int ADDR_PRIO0 = 2;
  localparam int ADDR_NEXT  = 6;
  localparam int ADDR_CTX   = 7;

  // next word fields
  localparam int NEXT_EMPTY_BIT = DATA_W - 1;
  localparam int NEXT_IDX_LSB   = 2;
  localparam int NEXT_UPD_BIT   = 0;

  // context word fields
  localparam int CTX_PRE_LSB   = 16;
  localparam int CTX_NUM_LSB   = 8;
  localparam int CTX_MSIE_BIT  = 3;
  localparam int CTX_MTIE_BIT  = 2;
  localparam int CTX_CLRTS_BIT = 1;

  function automatic logic [DATA_W-1:0] reg_apply(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] d,
                                                  input logic wr, input logic set,
                                                  input logic clr);
    if (wr)       return d;
    else if (set) return cur | d;
    else if (clr) return cur & ~d;
    else          return cur;
  endfunction
endpackage

// File: rtl/eirq_cfg.sv
module eirq_cfg import eirq_pkg::*; #(
  parameter int N_IRQ = NUM_IRQ,
  parameter int P_W   = PRIO_W,
  localparam int N_PW = (N_IRQ * P_W) / DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   wr_i,
  input  logic                   set_i,
  input  logic                   clr_i,
  input  logic [N_IRQ-1:0]       irq_i,
  output logic [N_IRQ-1:0]       en_o,
  output logic [N_IRQ-1:0]       pend_o,
  output logic [N_IRQ*P_W-1:0]   prio_o
);
  logic any_acc;
  assign any_acc = wr_i | set_i | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pend_o <= '0;
    end else begin
      pend_o <= irq_i;
      if (any_acc && addr_i == ADDR_W'(ADDR_EN))
        en_o <= reg_apply(en_o, wdata_i, wr_i, set_i, clr_i);
    end
  end

  for (genvar k = 0; k < N_PW; k++) begin : g_prio_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_o[k*DATA_W +: DATA_W] <= '0;
      else if (any_acc && addr_i == ADDR_W'(ADDR_PRIO0 + k))
        prio_o[k*DATA_W +: DATA_W] <=
          reg_apply(prio_o[k*DATA_W +: DATA_W], wdata_i, wr_i, set_i, clr_i);
    end
  end
endmodule

// File: rtl/eirq_prio_sel.sv
module eirq_prio_sel #(
  parameter int N_IRQ = 32,
  parameter int P_W   = 4,
  localparam int I_W  = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]     req_i,
  input  logic [N_IRQ*P_W-1:0] prio_i,
  input  logic [P_W:0]         thresh_i,
  output logic                 valid_o,
  output logic [I_W-1:0]       idx_o,
  output logic [P_W-1:0]       prio_o
);
  // ascending scan with strict compare: ties keep the lower number
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (req_i[i] && ({1'b0, prio_i[i*P_W +: P_W]} >= thresh_i) &&
          (!valid_o || prio_i[i*P_W +: P_W] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = I_W'(i);
        prio_o  = prio_i[i*P_W +: P_W];
      end
    end
  end
endmodule

// File: rtl/eirq_ctx.sv
module eirq_ctx import eirq_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [PRIO_W-1:0] upd_prio_i,
  input  logic              core_msie_i,
  input  logic              core_mtie_i,
  output logic [DATA_W-1:0] ctx_o,
  output logic [PRE_W-1:0]  thresh_o,
  output logic              ts_clr_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [IDX_W-1:0]  num_q;
  logic              msie_sv_q, mtie_sv_q;
  logic [DATA_W-1:0] nxt;
  logic              acc, ts_req;

  always_comb begin
    ctx_o = '0;
    ctx_o[CTX_PRE_LSB +: PRE_W] = pre_q;
    ctx_o[CTX_NUM_LSB +: IDX_W] = num_q;
    ctx_o[CTX_MSIE_BIT]         = msie_sv_q;
    ctx_o[CTX_MTIE_BIT]         = mtie_sv_q;
  end

  assign acc      = sel_i & (wr_i | set_i | clr_i);
  assign ts_req   = sel_i & (wr_i | set_i) & wdata_i[CTX_CLRTS_BIT];
  assign nxt      = reg_apply(ctx_o, wdata_i, wr_i, set_i, clr_i);
  assign thresh_o = pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      num_q     <= '0;
      msie_sv_q <= 1'b0;
      mtie_sv_q <= 1'b0;
      ts_clr_o  <= 1'b0;
    end else begin
      ts_clr_o <= ts_req;
      if (acc) begin
        pre_q <= nxt[CTX_PRE_LSB +: PRE_W];
        num_q <= nxt[CTX_NUM_LSB +: IDX_W];
        if (ts_req) begin
          msie_sv_q <= core_msie_i;
          mtie_sv_q <= core_mtie_i;
        end else begin
          msie_sv_q <= nxt[CTX_MSIE_BIT];
          mtie_sv_q <= nxt[CTX_MTIE_BIT];
        end
      end else if (upd_i) begin
        pre_q <= {1'b0, upd_prio_i} + PRE_W'(1);
        num_q <= upd_idx_i;
      end
    end
  end
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter import eirq_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               set_i,
  input  logic               clr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  input  logic               core_msie_i,
  input  logic               core_mtie_i,
  output logic               ts_clr_o
);
  logic [NUM_IRQ-1:0]        en, pend;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [PRE_W-1:0]          thresh;
  logic                      sel_valid;
  logic [IDX_W-1:0]          sel_idx;
  logic [PRIO_W-1:0]         sel_prio;
  logic [DATA_W-1:0]         ctx_word, next_word;
  logic                      upd;
  logic [DATA_W-1:0]         prio_words [NUM_PRIO_WORDS];
  logic [PW_IDX_W-1:0]       pw_idx;

  eirq_cfg #(.N_IRQ(NUM_IRQ), .P_W(PRIO_W)) i_cfg (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .set_i, .clr_i, .irq_i,
    .en_o(en), .pend_o(pend), .prio_o(prio_flat)
  );

  eirq_prio_sel #(.N_IRQ(NUM_IRQ), .P_W(PRIO_W)) i_sel (
    .req_i(pend & en), .prio_i(prio_flat), .thresh_i(thresh),
    .valid_o(sel_valid), .idx_o(sel_idx), .prio_o(sel_prio)
  );

  assign upd = set_i & (addr_i == ADDR_W'(ADDR_NEXT)) & wdata_i[NEXT_UPD_BIT] & sel_valid;

  eirq_ctx i_ctx (
    .clk_i, .rst_ni,
    .sel_i(addr_i == ADDR_W'(ADDR_CTX)), .wdata_i, .wr_i, .set_i, .clr_i,
    .upd_i(upd), .upd_idx_i(sel_idx), .upd_prio_i(sel_prio),
    .core_msie_i, .core_mtie_i,
    .ctx_o(ctx_word), .thresh_o(thresh), .ts_clr_o
  );

  always_comb begin
    next_word = '0;
    next_word[NEXT_EMPTY_BIT] = ~sel_valid;
    next_word[NEXT_IDX_LSB +: IDX_W] = sel_valid ? sel_idx : '0;
  end

  for (genvar k = 0; k < NUM_PRIO_WORDS; k++) begin : g_pw
    assign prio_words[k] = prio_flat[k*DATA_W +: DATA_W];
  end

  assign pw_idx = PW_IDX_W'(addr_i - ADDR_W'(ADDR_PRIO0));

  always_comb begin
    if (addr_i == ADDR_W'(ADDR_EN))            rdata_o = en;
    else if (addr_i == ADDR_W'(ADDR_PEND))     rdata_o = pend;
    else if (addr_i == ADDR_W'(ADDR_NEXT))     rdata_o = next_word;
    else if (addr_i == ADDR_W'(ADDR_CTX))      rdata_o = ctx_word;
    else                                       rdata_o = prio_words[pw_idx];
  end

  assign irq_o = sel_valid;
endmodule

// File: rtl/eirq_arbiter_chk.sv
module eirq_arbiter_chk import eirq_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_i,
  input logic               set_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic               ts_clr_o,
  input logic [NUM_IRQ-1:0] pend,
  input logic [DATA_W-1:0]  ctx_word
);
  localparam logic [DATA_W-1:0] CTX_MASK = 32'h001F_1F0C;
  logic past_ok;
  logic at_next, at_ctx, upd_acc, ts_acc;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assign at_next = addr_i == ADDR_W'(ADDR_NEXT);
  assign at_ctx  = addr_i == ADDR_W'(ADDR_CTX);
  assign upd_acc = at_next & set_i & wdata_i[NEXT_UPD_BIT];
  assign ts_acc  = at_ctx & (wr_i | set_i) & wdata_i[CTX_CLRTS_BIT];

  AST_EMPTY_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_next && rdata_o[NEXT_EMPTY_BIT]) |-> rdata_o[DATA_W-2:0] == '0); // R4
  AST_IRQ_MATCHES_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_next |-> (irq_o == !rdata_o[NEXT_EMPTY_BIT])); // R12
  AST_UPD_LOADS_NUM: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (upd_acc && !rdata_o[NEXT_EMPTY_BIT]) |=>
      ctx_word[CTX_NUM_LSB +: IDX_W] == $past(rdata_o[NEXT_IDX_LSB +: IDX_W])); // R6
  AST_UPD_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (upd_acc && rdata_o[NEXT_EMPTY_BIT]) |=> $stable(ctx_word)); // R7
  AST_PEND_TRACKS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    pend == $past(irq_i)); // R8
  AST_TS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    ts_acc |=> ts_clr_o); // R9
  AST_TS_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    ts_clr_o |-> $past(ts_acc)); // R9
  AST_CTX_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (at_ctx && wr_i && !wdata_i[CTX_CLRTS_BIT]) |=> ctx_word == $past(wdata_i & CTX_MASK)); // R10
endmodule

bind eirq_arbiter eirq_arbiter_chk i_chk (
  .clk_i, .rst_ni, .irq_i, .addr_i, .wdata_i, .wr_i, .set_i,
  .rdata_o, .irq_o, .ts_clr_o, .pend, .ctx_word
);

// File: tb/test_eirq_arbiter.sv
`timescale 1ns/1ps
module test_eirq_arbiter;
  logic        clk_i = 0, rst_ni = 0;
  logic [31:0] irq_i = 0, wdata_i = 0, rdata_o;
  logic [2:0]  addr_i = 0;
  logic        wr_i = 0, set_i = 0, clr_i = 0, irq_o, ts_clr_o;
  logic        core_msie_i = 0, core_mtie_i = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_en, m_irq;
  logic [3:0]  m_prio [32];
  logic [4:0]  m_pre, m_num;
  logic        m_ms, m_mt;

  always #2.5 clk_i = ~clk_i;

  eirq_arbiter i_eirq_arbiter (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic logic [31:0] exp_next();
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (m_irq[i] && m_en[i] && ({1'b0, m_prio[i]} >= m_pre) &&
          (best < 0 || m_prio[i] > m_prio[best])) best = i;
    return (best < 0) ? 32'h8000_0000 : (32'(best) << 2);
  endfunction

  function automatic logic [31:0] exp_ctx();
    return (32'(m_pre) << 16) | (32'(m_num) << 8) | (32'(m_ms) << 3) | (32'(m_mt) << 2);
  endfunction

  function automatic logic [31:0] prio_word(input int k);
    logic [31:0] w = 0;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = m_prio[8*k + j];
    return w;
  endfunction

  function automatic logic [31:0] apply(input logic [31:0] c, input logic [31:0] d,
                                        input bit w, input bit s, input bit cl);
    if (w) return d;
    if (s) return c | d;
    if (cl) return c & ~d;
    return c;
  endfunction

  task automatic bus(input logic [2:0] a, input logic [31:0] d, input bit w, input bit s,
                     input bit cl, output logic [31:0] r);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = w; set_i = s; clr_i = cl;
    #1 r = rdata_o;
    @(posedge clk_i);
    #1 wr_i = 0; set_i = 0; clr_i = 0;
  endtask

  task automatic drive_irq(input logic [31:0] v);
    @(negedge clk_i);
    irq_i = v; m_irq = v;
  endtask

  task automatic wr_prio_word(input int k, input logic [31:0] d, input bit w, input bit s, input bit cl);
    logic [31:0] r, nw;
    nw = apply(prio_word(k), d, w, s, cl);
    bus(3'(2 + k), d, w, s, cl, r);
    for (int j = 0; j < 8; j++) m_prio[8*k + j] = nw[4*j +: 4];
  endtask

  task automatic set_prio(input int i, input logic [3:0] p);
    m_prio[i] = p;
    wr_prio_word(i / 8, prio_word(i / 8), 1, 0, 0);
  endtask

  task automatic wr_en(input logic [31:0] d, input bit w, input bit s, input bit cl);
    logic [31:0] r;
    m_en = apply(m_en, d, w, s, cl);
    bus(3'd0, d, w, s, cl, r);
  endtask

  task automatic wr_ctx(input logic [4:0] pre, input logic [4:0] num, input bit ms, input bit mt);
    logic [31:0] r;
    m_pre = pre; m_num = num; m_ms = ms; m_mt = mt;
    bus(3'd7, exp_ctx(), 1, 0, 0, r);
  endtask

  // update access: check pre-update value, then context
  task automatic do_update(input string req);
    logic [31:0] r, e;
    e = exp_next();
    bus(3'd6, 32'h1, 0, 1, 0, r);
    check({req, " next"}, r, e);
    if (!e[31]) begin
      m_num = e[6:2];
      m_pre = {1'b0, m_prio[e[6:2]]} + 5'd1;
    end
    bus(3'd7, 0, 0, 0, 0, r);
    check({req, " ctx"}, r, exp_ctx());
  endtask

  task automatic chk_next(input string req);
    logic [31:0] r;
    bus(3'd6, 0, 0, 0, 0, r);
    check(req, r, exp_next());
    check({req, " R12 irq_o"}, 32'(irq_o), 32'(!exp_next()[31]));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_en = 0; m_irq = 0; m_pre = 0; m_num = 0; m_ms = 0; m_mt = 0;
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 ts_clr_o", 32'(ts_clr_o), 0);
    bus(3'd0, 0, 0, 0, 0, r); check("R1 enable", r, 0);
    bus(3'd3, 0, 0, 0, 0, r); check("R1 prio", r, 0);
    bus(3'd7, 0, 0, 0, 0, r); check("R1 ctx", r, 0);
    bus(3'd6, 0, 0, 0, 0, r); check("R1 next", r, 32'h8000_0000);

    // R11 set/clear/write on enable and priority
    wr_en(32'h0000_00F0, 1, 0, 0);
    wr_en(32'h0000_0F00, 0, 1, 0);
    wr_en(32'h0000_0030, 0, 0, 1);
    bus(3'd0, 0, 0, 0, 0, r); check("R11 enable set/clr", r, m_en);
    wr_prio_word(1, 32'h1234_5678, 1, 0, 0);
    wr_prio_word(1, 32'h0000_000F, 0, 0, 1);
    bus(3'd3, 0, 0, 0, 0, r); check("R11 prio clr", r, prio_word(1));
    for (int k = 0; k < 4; k++) wr_prio_word(k, 0, 1, 0, 0);
    wr_en(0, 1, 0, 0);

    // R8 late arrival, R2 index
    set_prio(3, 4'd2); set_prio(9, 4'd7);
    wr_en(32'h0000_0208, 1, 0, 0);
    drive_irq(32'h0000_0008);
    chk_next("R2 single");
    bus(3'd1, 0, 0, 0, 0, r); check("R8 pending", r, 32'h8);
    drive_irq(32'h0000_0208);
    do_update("R8 late arrival R6");
    check("R6 expected index 9", m_num, 9);
    chk_next("R5 below threshold after update");

    // R10 restore
    wr_ctx(0, 0, 0, 0);
    bus(3'd7, 0, 0, 0, 0, r); check("R10 ctx restore", r, 0);
    chk_next("R10 next after restore");

    // R5 threshold equal / above
    wr_ctx(5'd7, 5'd3, 0, 0); chk_next("R5 equal eligible");
    check("R5 idx 9", exp_next(), 32'h24);
    wr_ctx(5'd8, 5'd3, 0, 0); chk_next("R5 above empty R4");
    check("R4 model empty", exp_next(), 32'h8000_0000);

    // R7 update while empty
    do_update("R7 empty update");

    // R3 ties
    wr_ctx(0, 0, 0, 0);
    set_prio(5, 4'd9); set_prio(20, 4'd9); set_prio(30, 4'd9);
    wr_en(32'h4010_0020, 1, 0, 0);
    drive_irq(32'h4010_0020);
    chk_next("R3 tie");
    check("R3 tie winner", exp_next(), 32'h14);

    // R11 ignored writes to pending and next
    bus(3'd1, 32'hFFFF_FFFF, 1, 0, 0, r);
    bus(3'd1, 0, 0, 0, 0, r); check("R11 pending write ignored", r, m_irq);
    bus(3'd6, 32'hFFFF_FFFE, 1, 0, 0, r);
    bus(3'd7, 0, 0, 0, 0, r); check("R11 next write ignored ctx", r, exp_ctx());
    chk_next("R11 next unchanged");

    // R9 clearts
    core_msie_i = 1; core_mtie_i = 0;
    bus(3'd7, 32'h2, 0, 1, 0, r);
    m_ms = 1; m_mt = 0;
    check("R9 ts_clr pulse", 32'(ts_clr_o), 1);
    bus(3'd7, 0, 0, 0, 0, r);
    check("R9 ts_clr ends", 32'(ts_clr_o), 0);
    check("R9 saved enables", r, exp_ctx());
    core_msie_i = 0; core_mtie_i = 1;
    bus(3'd7, 32'h2, 1, 0, 0, r);
    m_pre = 0; m_num = 0; m_ms = 0; m_mt = 1;
    bus(3'd7, 0, 0, 0, 0, r); check("R9 write clearts", r, exp_ctx());

    // random mix
    wr_ctx(0, 0, 0, 0);
    for (int it = 0; it < 400; it++) begin
      drive_irq($urandom);
      if ($urandom_range(0, 3) == 0) wr_en($urandom, 1, 0, 0);
      else if ($urandom_range(0, 1) == 0) wr_en($urandom, 0, 1, 0);
      else wr_en($urandom, 0, 0, 1);
      if ($urandom_range(0, 2) == 0) wr_prio_word($urandom_range(0, 3), $urandom, 1, 0, 0);
      if ($urandom_range(0, 4) == 0)
        wr_ctx(5'($urandom_range(0, 17)), 5'($urandom_range(0, 31)), 1'($urandom), 1'($urandom));
      chk_next("R2 random");
      if ($urandom_range(0, 2) == 0) do_update("R6 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule